// File: doc/BRIEF.md
# Serial Configuration Chain Access Port

This block lets software reach a long serial chain of configuration registers six bits at a time, through two 64-bit register addresses. One address is a six-bit data window. The other is a one-bit shift trigger. A write to the data window only stages six bits inside the block. Those bits travel into the chain when a later commit strobe confirms that write. If the write is flushed first, nothing travels.

To read the chain, software writes 1 to the trigger. The block then pulls six bits off the chain's output end and feeds each one straight back into the chain's input end. Software then reads the captured bits from the data window. Every transfer, in either direction, lasts exactly six cycles with the shift enable high, least significant bit first. A busy output covers the whole transfer.

The block never interprets the chain contents. Some chain registers are duplicate copies that software must keep equal to their originals. The block passes those bits through unchanged and does not compare them.

Top module: `csr_chain_port`

## Requirements
- R1: After reset, busy, chain_shift_en and chain_sout are 0, and both registers read as all zeros.
- R2: A data write (reg_wr_sel = 0) accepted while idle stages bits [5:0] and discards bits [63:6]. Reading the data register then returns the staged bits with [63:6] as zero, and the chain is not shifted.
- R3: A commit strobe with a staged write, while idle, causes chain_shift_en and busy to be high for exactly the six following cycles. chain_sout carries staged bit i in the i-th of those cycles. Afterwards the chain holds the six bits and the data register reads zero.
- R4: A commit strobe with no staged write has no effect: no shift and no busy.
- R5: A flush strobe while a write is staged discards it: the data register reads zero and a later commit shifts nothing.
- R6: Writing 1 to bit 0 of the trigger register (reg_wr_sel = 1) while idle with nothing staged starts a six-cycle readback. Bit i of the data register becomes the i-th bit received on chain_sin. Each received bit is echoed on chain_sout in the same cycle.
- R7: A trigger register write with bit 0 clear, whatever the other bits hold, does nothing.
- R8: While busy, data writes, trigger writes, commit and flush are all ignored.
- R9: A trigger write while a write is staged is ignored, and the staged bits remain readable.
- R10: The trigger register always reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | Write target: 0 = data register, 1 = trigger register |
| reg_wr_data | input | 64 | Write data |
| reg_rd_sel | input | 1 | Read target: 0 = data register, 1 = trigger register |
| reg_rd_data | output | 64 | Read data (combinational) |
| commit | input | 1 | Commit strobe for the staged data write |
| flush | input | 1 | Discard strobe for the staged data write |
| busy | output | 1 | High while a six-bit transfer runs |
| chain_shift_en | output | 1 | Shift enable toward the chain |
| chain_sout | output | 1 | Serial bit into the chain |
| chain_sin | input | 1 | Serial bit out of the chain |

## Verification
The staged value and the read mux settle one cycle after the write edge, so the bench reads back at the falling edge that follows that edge. Busy and the shift enable rise in the cycle after the commit or trigger edge and stay high for the next six cycles. The bench samples chain_sout at each of the six falling edges that follow the start edge. It then tests the chain model and the data register at the seventh falling edge, when the transfer has ended. Requests that should be ignored are judged from a shift-enable counter taken over a window of eight or more cycles, and from the unchanged chain model and data register.

// File: rtl/csr_chain_pkg.sv
package csr_chain_pkg;
    localparam int REG_W_DEF  = 64;
    localparam int DATA_W_DEF = 6;

    typedef enum logic {
        XFER_PUSH = 1'b0,
        XFER_PULL = 1'b1
    } xfer_dir_e;
endpackage

// File: rtl/csr_chain_decode.sv
module csr_chain_decode #(
    parameter int REG_W  = csr_chain_pkg::REG_W_DEF,
    parameter int DATA_W = csr_chain_pkg::DATA_W_DEF
) (
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_sel,
    input  logic [DATA_W-1:0] window,
    output logic              stage_wr,
    output logic [DATA_W-1:0] stage_val,
    output logic              trig,
    output logic [REG_W-1:0]  rd_data
);
    localparam int PAD_W = REG_W - DATA_W;

    logic unused_rsvd;

    always_comb begin
        stage_wr  = wr_en && !wr_sel;
        stage_val = wr_data[DATA_W-1:0];
        trig      = wr_en && wr_sel && wr_data[0];
        if (rd_sel) begin
            rd_data = '0;
        end else begin
            rd_data = {{PAD_W{1'b0}}, window};
        end
    end

    assign unused_rsvd = ^wr_data[REG_W-1:DATA_W];
endmodule

// File: rtl/csr_chain_ctrl.sv
module csr_chain_ctrl #(
    parameter int DATA_W = csr_chain_pkg::DATA_W_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stage_wr,
    input  logic trig,
    input  logic commit,
    input  logic flush,
    output logic busy,
    output logic pull,
    output logic pending,
    output logic load,
    output logic clear
);
    import csr_chain_pkg::*;

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic             busy;
        xfer_dir_e        dir;
        logic             pending;
        logic [CNT_W-1:0] cnt;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic start_push_d, start_pull_d, do_flush_d, do_stage_d;

    always_comb begin
        st_d         = st_q;
        start_push_d = commit && st_q.pending && !st_q.busy;
        start_pull_d = trig && !st_q.pending && !st_q.busy;
        do_flush_d   = flush && st_q.pending && !st_q.busy && !start_push_d;
        do_stage_d   = stage_wr && !st_q.busy && !start_push_d && !do_flush_d;

        if (st_q.busy) begin
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (start_push_d) begin
            st_d.busy    = 1'b1;
            st_d.dir     = XFER_PUSH;
            st_d.pending = 1'b0;
            st_d.cnt     = '0;
        end else if (start_pull_d) begin
            st_d.busy = 1'b1;
            st_d.dir  = XFER_PULL;
            st_d.cnt  = '0;
        end else if (do_flush_d) begin
            st_d.pending = 1'b0;
        end else if (do_stage_d) begin
            st_d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, dir: XFER_PUSH, pending: 1'b0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = st_q.busy;
    assign pull    = (st_q.dir == XFER_PULL);
    assign pending = st_q.pending;
    assign load    = do_stage_d;
    assign clear   = do_flush_d;
endmodule

// File: rtl/csr_chain_shreg.sv
module csr_chain_shreg #(
    parameter int DATA_W = csr_chain_pkg::DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              clear,
    input  logic              shift,
    input  logic              pull,
    input  logic              sin,
    output logic              sout,
    output logic [DATA_W-1:0] value
);
    logic [DATA_W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (shift) begin
            if (pull) begin
                val_d = {sin, val_q[DATA_W-1:1]};
            end else begin
                val_d = {1'b0, val_q[DATA_W-1:1]};
            end
        end else if (clear) begin
            val_d = '0;
        end else if (load) begin
            val_d = load_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign sout  = shift ? (pull ? sin : val_q[0]) : 1'b0;
    assign value = val_q;
endmodule

// File: rtl/csr_chain_port.sv
module csr_chain_port #(
    parameter int REG_W  = csr_chain_pkg::REG_W_DEF,
    parameter int DATA_W = csr_chain_pkg::DATA_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic             reg_wr_sel,
    input  logic [REG_W-1:0] reg_wr_data,
    input  logic             reg_rd_sel,
    output logic [REG_W-1:0] reg_rd_data,
    input  logic             commit,
    input  logic             flush,
    output logic             busy,
    output logic             chain_shift_en,
    output logic             chain_sout,
    input  logic             chain_sin
);
    logic              stage_wr_w, trig_w, pull_w, pending_w, load_w, clear_w, busy_w;
    logic [DATA_W-1:0] stage_val_w, window_w;

    csr_chain_decode #(.REG_W(REG_W), .DATA_W(DATA_W)) dec_i (
        .wr_en     (reg_wr_en),
        .wr_sel    (reg_wr_sel),
        .wr_data   (reg_wr_data),
        .rd_sel    (reg_rd_sel),
        .window    (window_w),
        .stage_wr  (stage_wr_w),
        .stage_val (stage_val_w),
        .trig      (trig_w),
        .rd_data   (reg_rd_data)
    );

    csr_chain_ctrl #(.DATA_W(DATA_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .stage_wr (stage_wr_w),
        .trig     (trig_w),
        .commit   (commit),
        .flush    (flush),
        .busy     (busy_w),
        .pull     (pull_w),
        .pending  (pending_w),
        .load     (load_w),
        .clear    (clear_w)
    );

    csr_chain_shreg #(.DATA_W(DATA_W)) sh_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_w),
        .load_val (stage_val_w),
        .clear    (clear_w),
        .shift    (busy_w),
        .pull     (pull_w),
        .sin      (chain_sin),
        .sout     (chain_sout),
        .value    (window_w)
    );

    assign busy           = busy_w;
    assign chain_shift_en = busy_w;
endmodule

// File: rtl/csr_chain_port_chk.sv
module csr_chain_port_chk #(
    parameter int REG_W  = 64,
    parameter int DATA_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic              reg_wr_sel,
    input logic [REG_W-1:0]  reg_wr_data,
    input logic              commit,
    input logic              flush,
    input logic              busy,
    input logic              chain_shift_en,
    input logic              pending,
    input logic [DATA_W-1:0] window
);
    localparam int RUN_W = $clog2(DATA_W + 1) + 1;

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    AST_STAGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !reg_wr_sel && !busy && !commit && !flush)
        |=> (pending && window == $past(reg_wr_data[DATA_W-1:0]))); // R2
    AST_STAGED_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> !chain_shift_en); // R2
    AST_RUN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(DATA_W)); // R3
    AST_RUN_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == RUN_W'(DATA_W))); // R3
    AST_EMPTY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !pending && !busy && !(reg_wr_en && reg_wr_sel && reg_wr_data[0]))
        |=> !busy); // R4
    AST_FLUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && pending && !busy && !commit) |=> (!pending && window == '0)); // R5
    AST_TRIG_START: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wr_sel && reg_wr_data[0] && !busy && !pending) |=> busy); // R6
    AST_ZERO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wr_sel && !reg_wr_data[0] && !busy && !(commit && pending))
        |=> !busy); // R7
    AST_BUSY_NO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !pending); // R8
    AST_STAGED_BLOCKS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !busy && !commit) |=> !busy); // R9
endmodule

bind csr_chain_port csr_chain_port_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_wr_en      (reg_wr_en),
    .reg_wr_sel     (reg_wr_sel),
    .reg_wr_data    (reg_wr_data),
    .commit         (commit),
    .flush          (flush),
    .busy           (busy),
    .chain_shift_en (chain_shift_en),
    .pending        (pending_w),
    .window         (window_w)
);

// File: tb/csr_chain_port_tb_top.sv
`timescale 1ns/1ps
module csr_chain_port_tb_top;
    localparam int REG_W  = 64;
    localparam int DATA_W = 6;
    localparam int CH_LEN = 12;
    localparam int NVEC   = 6;
    localparam logic [REG_W-1:0] VECS [NVEC] = '{
        64'hA5A5_0000_0000_0015,
        64'h0000_0000_0000_002A,
        64'hFFFF_FFFF_FFFF_FFFF,
        64'h8000_0000_0000_0000,
        64'h1234_5678_9ABC_DE01,
        64'h0F0F_0F0F_0F0F_0F60
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr_en = 1'b0;
    logic             reg_wr_sel = 1'b0;
    logic [REG_W-1:0] reg_wr_data = '0;
    logic             reg_rd_sel = 1'b0;
    logic [REG_W-1:0] reg_rd_data;
    logic             commit = 1'b0;
    logic             flush = 1'b0;
    logic             busy, chain_shift_en, chain_sout, chain_sin;

    int total = 0;
    int bad = 0;
    int shifts = 0;

    logic [CH_LEN-1:0] ch;
    logic              ch_ld = 1'b0;
    logic [CH_LEN-1:0] ch_ld_val = '0;

    always #2.5 clk = ~clk;

    csr_chain_port #(.REG_W(REG_W), .DATA_W(DATA_W)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_wr_en      (reg_wr_en),
        .reg_wr_sel     (reg_wr_sel),
        .reg_wr_data    (reg_wr_data),
        .reg_rd_sel     (reg_rd_sel),
        .reg_rd_data    (reg_rd_data),
        .commit         (commit),
        .flush          (flush),
        .busy           (busy),
        .chain_shift_en (chain_shift_en),
        .chain_sout     (chain_sout),
        .chain_sin      (chain_sin)
    );

    // Chain model: enters at the top end, leaves at bit 0.
    always @(posedge clk) begin
        if (ch_ld) begin
            ch <= ch_ld_val;
        end else if (chain_shift_en) begin
            ch <= {chain_sout, ch[CH_LEN-1:1]};
        end
        if (chain_shift_en) begin
            shifts <= shifts + 1;
        end
    end
    assign chain_sin = ch[0];

    task automatic check(input string tag, input logic [REG_W-1:0] act, input logic [REG_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic read_reg(input logic sel, output logic [REG_W-1:0] val);
        reg_rd_sel = sel;
        #0.5;
        val = reg_rd_data;
    endtask

    task automatic write_reg(input logic sel, input logic [REG_W-1:0] d);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_sel  = sel;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en   = 1'b0;
        reg_wr_data = '0;
    endtask

    task automatic pulse_commit();
        @(negedge clk);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
    endtask

    task automatic pulse_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [REG_W-1:0]  rv;
        logic [CH_LEN-1:0] pre;
        logic [DATA_W-1:0] exp6;
        int                s0;

        ch_ld     = 1'b1;
        ch_ld_val = 12'hB4D;
        repeat (4) @(negedge clk);
        ch_ld = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", 64'(busy), 64'h0);
        check("R1 shift_en", 64'(chain_shift_en), 64'h0);
        check("R1 sout", 64'(chain_sout), 64'h0);
        read_reg(1'b0, rv); check("R1 data reg", rv, 64'h0);
        read_reg(1'b1, rv); check("R10 trigger reg", rv, 64'h0);

        // Vector table: stage, commit, then read the chain head back
        for (int i = 0; i < NVEC; i++) begin
            exp6 = VECS[i][DATA_W-1:0];
            s0 = shifts;
            write_reg(1'b0, VECS[i]);
            read_reg(1'b0, rv); check("R2 staged readback", rv, 64'(exp6));
            idle(2);
            check("R2 no shift before commit", 64'(shifts - s0), 64'h0);
            pre = ch;
            pulse_commit();
            for (int k = 0; k < DATA_W; k++) begin
                check("R3 busy in transfer", 64'(busy), 64'h1);
                check("R3 sout bit", 64'(chain_sout), 64'(exp6[k]));
                @(negedge clk);
            end
            check("R3 busy ends", 64'(busy), 64'h0);
            check("R3 shift count", 64'(shifts - s0), 64'd6);
            check("R3 chain content", 64'(ch), 64'({exp6, pre[CH_LEN-1:DATA_W]}));
            read_reg(1'b0, rv); check("R3 data after push", rv, 64'h0);

            pre = ch;
            s0 = shifts;
            write_reg(1'b1, 64'h1);
            for (int k = 0; k < DATA_W; k++) begin
                check("R6 sout echoes sin", 64'(chain_sout), 64'(chain_sin));
                @(negedge clk);
            end
            check("R6 shift count", 64'(shifts - s0), 64'd6);
            read_reg(1'b0, rv); check("R6 captured bits", rv, 64'(pre[DATA_W-1:0]));
            check("R6 chain rotated", 64'(ch), 64'({pre[DATA_W-1:0], pre[CH_LEN-1:DATA_W]}));
            read_reg(1'b1, rv); check("R10 trigger reg", rv, 64'h0);
        end

        // R4 commit with nothing staged
        pre = ch; s0 = shifts;
        pulse_commit();
        idle(8);
        check("R4 no shift", 64'(shifts - s0), 64'h0);
        check("R4 chain kept", 64'(ch), 64'(pre));

        // R5 flush discards
        write_reg(1'b0, 64'h2D);
        pulse_flush();
        read_reg(1'b0, rv); check("R5 data cleared", rv, 64'h0);
        pulse_commit();
        idle(8);
        check("R5 no shift", 64'(shifts - s0), 64'h0);
        check("R5 chain kept", 64'(ch), 64'(pre));

        // R7 zero trigger write
        write_reg(1'b0, 64'h17);
        pulse_flush();
        write_reg(1'b1, 64'h1);
        idle(8);
        read_reg(1'b0, rv);
        pre = ch; s0 = shifts;
        write_reg(1'b1, 64'hFFFF_FFFF_FFFF_FFFE);
        idle(8);
        check("R7 no shift", 64'(shifts - s0), 64'h0);
        begin
            logic [REG_W-1:0] rv2;
            read_reg(1'b0, rv2); check("R7 data kept", rv2, rv);
        end

        // R9 trigger while staged
        write_reg(1'b0, 64'h11);
        write_reg(1'b1, 64'h1);
        idle(8);
        check("R9 no shift", 64'(shifts - s0), 64'h0);
        read_reg(1'b0, rv); check("R9 staged kept", rv, 64'h11);
        pulse_commit();
        idle(8);
        check("R9 later commit shifts", 64'(shifts - s0), 64'd6);

        // R8 requests during busy are ignored
        pre = ch; s0 = shifts;
        write_reg(1'b0, 64'h33);
        @(negedge clk); commit = 1'b1;
        @(negedge clk); commit = 1'b0;
        reg_wr_en = 1'b1; reg_wr_sel = 1'b1; reg_wr_data = 64'h1;
        @(negedge clk); reg_wr_sel = 1'b0; reg_wr_data = 64'h0A;
        @(negedge clk); reg_wr_en = 1'b0; reg_wr_data = '0; flush = 1'b1;
        @(negedge clk); flush = 1'b0; commit = 1'b1;
        @(negedge clk); commit = 1'b0;
        idle(10);
        check("R8 only one transfer", 64'(shifts - s0), 64'd6);
        check("R8 chain holds first write", 64'(ch[CH_LEN-1 -: DATA_W]), 64'h33);
        read_reg(1'b0, rv); check("R8 data write ignored", rv, 64'h0);
        check("R8 idle after", 64'(busy), 64'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule